// File: doc/BRIEF.md
# Low-Side Switch Serial Command Slave

This block is the digital control core of a sixteen-channel low-side output switch. A host talks to it through an SPI slave port. Every transaction is one 16-bit frame inside a chip-select window. The upper byte of a frame is a command and the lower byte is data. Two 8-bit output registers hold the serially commanded state: one for channels 0–7 and one for channels 8–15. Eight parallel drive pins can also switch channels 0–3 and 8–11 directly. The block ORs each of these pins with the matching register bit to form the sixteen channel enables.

Replies are pipelined by one frame. Whatever a frame asks for is shifted out on MISO during the next frame. A frame can ask for the full 2-bit fault code of each channel in one bank, for the parallel-pin states plus a condensed fault byte, or for a loopback in which the next frame's MISO copies MOSI. The fault codes arrive on plain inputs from the analog side. The SPI pins are sampled by the system clock through synchronizers, so the host cannot stall a frame and the block has no back-pressure: every frame of exactly sixteen clocks is accepted, and every other frame is dropped.

Top module: `lss_serial_ctrl`

## Requirements
- R1: SPI mode 0, most significant bit first. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. Frame bits 15:12 are the opcode, bits 11:8 the bank selector and bits 7:0 the data.
- R2: Bank selector 4'h0 addresses channels 0–7 and 4'hF addresses channels 8–15. Any other selector leaves all state unchanged and makes the next reply 16'hFFFF.
- R3: Opcode 4'h3 sets the addressed register to its old value OR the data byte.
- R4: Opcode 4'hF sets the addressed register to its old value AND the data byte.
- R5: After opcode 4'h3, 4'hF or 4'h0, the next frame returns the fault codes of the addressed bank, captured at the end of the commanding frame. Channel n of the bank sits in reply bits 2n+1:2n, taken from fault_code. The codes are 11 no fault, 10 overload or overtemperature, 01 open load and 00 short to ground.
- R6: Opcode 4'h0 ignores its data byte and changes no output register.
- R7: Opcode 4'hC changes no register. Its reply carries parallel pins 7:4 (channels 11:8) in bits 15:12 and pins 3:0 (channels 3:0) in bits 11:8. Bit k of the low byte is 1 only when channels k and k+8 both report code 11.
- R8: Opcode 4'hA arms loopback. During the next frame MISO follows MOSI bit for bit. That frame is not decoded, and the reply after it is 16'hFFFF.
- R9: chan_on[n] is the register bit for every channel. For channels 0–3 and 8–11 it is additionally ORed with parallel pin n (channels 0–3) or pin n-4 (channels 8–11).
- R10: After reset both registers are zero and the first reply frame is 16'hFFFF.
- R11: A frame with any number of clocks other than sixteen changes no register, no loopback state and no pending reply.
- R12: Opcodes other than 0x0, 0x3, 0xA, 0xC and 0xF change nothing, and the next reply is 16'hFFFF.
- R13: MISO is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial reply to host |
| direct_in | input | 8 | Parallel drive pins: 3:0 for channels 3:0, 7:4 for channels 11:8 |
| fault_code | input | 32 | 2-bit fault code per channel, channel n at bits 2n+1:2n |
| chan_on | output | 16 | Channel enables after merging |

## Verification
The bench checks that the reply pipeline stays exactly one frame deep across a chain of mixed commands. If the captured word were returned in the same frame, or a frame too late, every comparison after the first would slip. It sends 12- and 17-clock frames and confirms that the following good frame still returns the reply pending before them; a design that counted loosely would apply a truncated write or lose that reply. In the loopback frame it sends a valid write word and checks that MISO mirrors it while the registers stay unchanged; a design that also decoded that frame would set outputs. Unknown opcodes and bank nibbles must give an all-ones reply, and a design that wrote to a bank anyway would show up on chan_on.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [3:0] {
    OP_DIAG  = 4'h0,
    OP_OR    = 4'h3,
    OP_ECHO  = 4'hA,
    OP_INPUT = 4'hC,
    OP_AND   = 4'hF
  } lss_op_e;

  localparam logic [3:0] BANK_SEL_LO = 4'h0;
  localparam logic [3:0] BANK_SEL_HI = 4'hF;
  localparam logic [15:0] REPLY_IDLE = 16'hFFFF;
endpackage

// File: rtl/lss_frame_port.sv
module lss_frame_port #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  input  logic [FRAME_BITS-1:0] reply_word,
  input  logic                  echo_en,
  output logic                  miso,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_SAT = FRAME_BITS + 1;

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic                   sclk_d, cs_d;
  logic                   sclk_s, cs_s, mosi_s;
  logic                   sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic [CNT_W-1:0]       bit_cnt;
  logic [FRAME_BITS-1:0]  rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      sclk_d    <= sclk_sync[SYNC_STAGES-1];
      cs_d      <= cs_sync[SYNC_STAGES-1];
    end
  end

  assign sclk_s    = sclk_sync[SYNC_STAGES-1];
  assign cs_s      = cs_sync[SYNC_STAGES-1];
  assign mosi_s    = mosi_sync[SYNC_STAGES-1];
  assign sclk_rise = !cs_s && sclk_s && !sclk_d;
  assign sclk_fall = !cs_s && !sclk_s && sclk_d;
  assign cs_fall   = cs_d && !cs_s;
  assign cs_rise   = !cs_d && cs_s;

  // receive side: count and shift while selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (sclk_rise) begin
      rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
      if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      frame_valid <= cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
      if (cs_rise) frame_word <= rx_sh;
    end
  end

  // transmit side: preload while idle, shift on falling SCLK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
    end else if (cs_s) begin
      tx_sh <= reply_word;
    end else if (sclk_fall) begin
      tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_comb begin
    if (cs_n)         miso = 1'b0;
    else if (echo_en) miso = mosi;
    else              miso = tx_sh[FRAME_BITS-1];
  end
endmodule

// File: rtl/lss_cmd_core.sv
module lss_cmd_core
  import lss_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int DIRECT   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  input  logic [15:0]           frame_word,
  input  logic [2*CHANNELS-1:0] fault_code,
  input  logic [DIRECT-1:0]     direct_in,
  output logic [CHANNELS-1:0]   out_reg,
  output logic [15:0]           reply_word,
  output logic                  echo_en
);
  localparam int BANK_W = CHANNELS / 2;
  localparam int DIAG_W = 2 * BANK_W;

  logic [BANK_W-1:0] bank_lo, bank_hi;
  logic [BANK_W-1:0] bank_lo_nxt, bank_hi_nxt;
  logic [15:0]       reply_nxt;
  logic              echo_nxt;
  logic [BANK_W-1:0] short_ok;
  lss_op_e           op;
  logic [3:0]        bank_sel;
  logic [7:0]        data;
  logic              sel_hi, sel_ok;
  logic [DIAG_W-1:0] diag_lo, diag_hi, diag_sel;
  logic [BANK_W-1:0] cur_bank, upd_bank;

  genvar k;
  generate
    for (k = 0; k < BANK_W; k++) begin : g_short
      assign short_ok[k] = (&fault_code[2*k +: 2]) & (&fault_code[2*(k+BANK_W) +: 2]);
    end
  endgenerate

  assign diag_lo  = fault_code[DIAG_W-1:0];
  assign diag_hi  = fault_code[2*DIAG_W-1:DIAG_W];
  assign op       = lss_op_e'(frame_word[15:12]);
  assign bank_sel = frame_word[11:8];
  assign data     = frame_word[7:0];
  assign sel_hi   = (bank_sel == BANK_SEL_HI);
  assign sel_ok   = (bank_sel == BANK_SEL_LO) || sel_hi;
  assign diag_sel = sel_hi ? diag_hi : diag_lo;
  assign cur_bank = sel_hi ? bank_hi : bank_lo;

  always_comb begin
    bank_lo_nxt = bank_lo;
    bank_hi_nxt = bank_hi;
    reply_nxt   = reply_word;
    echo_nxt    = echo_en;
    upd_bank    = cur_bank;
    if (frame_valid) begin
      reply_nxt = REPLY_IDLE;
      if (echo_en) begin
        echo_nxt = 1'b0;
      end else if (sel_ok) begin
        case (op)
          OP_OR: begin
            upd_bank  = cur_bank | data;
            reply_nxt = diag_sel;
          end
          OP_AND: begin
            upd_bank  = cur_bank & data;
            reply_nxt = diag_sel;
          end
          OP_DIAG:  reply_nxt = diag_sel;
          OP_INPUT: reply_nxt = {direct_in, short_ok};
          OP_ECHO:  echo_nxt  = 1'b1;
          default:  reply_nxt = REPLY_IDLE;
        endcase
        if (sel_hi) bank_hi_nxt = upd_bank;
        else        bank_lo_nxt = upd_bank;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_lo    <= '0;
      bank_hi    <= '0;
      reply_word <= REPLY_IDLE;
      echo_en    <= 1'b0;
    end else begin
      bank_lo    <= bank_lo_nxt;
      bank_hi    <= bank_hi_nxt;
      reply_word <= reply_nxt;
      echo_en    <= echo_nxt;
    end
  end

  assign out_reg = {bank_hi, bank_lo};
endmodule

// File: rtl/lss_out_merge.sv
module lss_out_merge #(
  parameter int CHANNELS = 16,
  parameter int DIRECT   = 8
) (
  input  logic [CHANNELS-1:0] out_reg,
  input  logic [DIRECT-1:0]   direct_in,
  output logic [CHANNELS-1:0] chan_on
);
  localparam int BANK_W   = CHANNELS / 2;
  localparam int PER_BANK = DIRECT / 2;

  genvar n;
  generate
    for (n = 0; n < CHANNELS; n++) begin : g_ch
      if (n < PER_BANK) begin : g_dlo
        assign chan_on[n] = out_reg[n] | direct_in[n];
      end else if (n >= BANK_W && n < BANK_W + PER_BANK) begin : g_dhi
        assign chan_on[n] = out_reg[n] | direct_in[n - BANK_W + PER_BANK];
      end else begin : g_ser
        assign chan_on[n] = out_reg[n];
      end
    end
  endgenerate
endmodule

// File: rtl/lss_serial_ctrl.sv
module lss_serial_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CHANNELS    = 16,
  parameter int DIRECT      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  input  logic [DIRECT-1:0]     direct_in,
  input  logic [2*CHANNELS-1:0] fault_code,
  output logic [CHANNELS-1:0]   chan_on
);
  localparam int FRAME_BITS = 16;

  logic                  frame_valid;
  logic [FRAME_BITS-1:0] frame_word;
  logic [FRAME_BITS-1:0] reply_word;
  logic                  echo_en;
  logic [CHANNELS-1:0]   out_reg;

  lss_frame_port #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .reply_word(reply_word), .echo_en(echo_en), .miso(spi_miso),
    .frame_valid(frame_valid), .frame_word(frame_word)
  );

  lss_cmd_core #(.CHANNELS(CHANNELS), .DIRECT(DIRECT)) u_core (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_word(frame_word),
    .fault_code(fault_code), .direct_in(direct_in), .out_reg(out_reg),
    .reply_word(reply_word), .echo_en(echo_en)
  );

  lss_out_merge #(.CHANNELS(CHANNELS), .DIRECT(DIRECT)) u_merge (
    .out_reg(out_reg), .direct_in(direct_in), .chan_on(chan_on)
  );
endmodule

// File: rtl/lss_serial_ctrl_chk.sv
module lss_serial_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_miso,
  input logic        frame_valid,
  input logic [15:0] frame_word,
  input logic [15:0] out_reg,
  input logic [15:0] chan_on,
  input logic [7:0]  direct_in,
  input logic        echo_en
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(out_reg));

  a_r3_or_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !echo_en && frame_word[15:8] == 8'h30)
    |=> ((out_reg[7:0] & $past(frame_word[7:0])) == $past(frame_word[7:0])));

  a_r4_and_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !echo_en && frame_word[15:8] == 8'hF0)
    |=> ((out_reg[7:0] & ~$past(frame_word[7:0])) == 8'h00));

  a_r8_echo_one_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && echo_en) |=> (!echo_en && $stable(out_reg)));

  a_r9_merge_cover: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_on & out_reg) == out_reg) &&
    ((chan_on[3:0] & direct_in[3:0]) == direct_in[3:0]) &&
    ((chan_on[11:8] & direct_in[7:4]) == direct_in[7:4]));

  a_r13_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso);
endmodule

bind lss_serial_ctrl lss_serial_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .frame_valid(frame_valid), .frame_word(frame_word), .out_reg(out_reg),
  .chan_on(chan_on), .direct_in(direct_in), .echo_en(echo_en)
);

// File: tb/tb_lss_serial_ctrl.sv
module tb_lss_serial_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic [7:0]  direct_in = '0;
  logic [31:0] fault_code = '1;
  logic [15:0] chan_on;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_lo = '0, m_hi = '0;
  logic [15:0] m_reply = 16'hFFFF;
  logic        m_echo = 1'b0;

  always #2.5 clk = ~clk;

  lss_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .direct_in(direct_in),
    .fault_code(fault_code), .chan_on(chan_on)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    spi_cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? tx[15-i] : 1'b0;
      wait_clk(4);
      rx = {rx[14:0], spi_miso};
      spi_sclk = 1'b1;
      wait_clk(8);
      spi_sclk = 1'b0;
      wait_clk(4);
    end
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(10);
  endtask

  function automatic logic [15:0] exp_chan();
    return {m_hi[7:4], m_hi[3:0] | direct_in[7:4], m_lo[7:4], m_lo[3:0] | direct_in[3:0]};
  endfunction

  // reference model built from the requirements
  task automatic model(input logic [15:0] w);
    logic [3:0] op, sel;
    logic [7:0] cur, d;
    logic       hi;
    logic [7:0] shortb;
    op = w[15:12]; sel = w[11:8]; d = w[7:0];
    hi = (sel == 4'hF);
    cur = hi ? m_hi : m_lo;
    for (int k = 0; k < 8; k++)
      shortb[k] = (fault_code[2*k +: 2] == 2'b11) && (fault_code[2*(k+8) +: 2] == 2'b11);
    if (m_echo) begin
      m_echo = 1'b0; m_reply = 16'hFFFF;
    end else if (sel != 4'h0 && sel != 4'hF) begin
      m_reply = 16'hFFFF;
    end else begin
      m_reply = 16'hFFFF;
      case (op)
        4'h3: begin cur = cur | d; m_reply = hi ? fault_code[31:16] : fault_code[15:0]; end
        4'hF: begin cur = cur & d; m_reply = hi ? fault_code[31:16] : fault_code[15:0]; end
        4'h0: m_reply = hi ? fault_code[31:16] : fault_code[15:0];
        4'hC: m_reply = {direct_in, shortb};
        4'hA: m_echo = 1'b1;
        default: ;
      endcase
      if (hi) m_hi = cur; else m_lo = cur;
    end
  endtask

  task automatic do_frame(input logic [15:0] tx, input string req);
    logic [15:0] rx, exp;
    exp = m_echo ? tx : m_reply;
    spi_xfer(tx, 16, rx);
    check(rx === exp, req, {16'h0, rx}, {16'h0, exp});
    model(tx);
    check(chan_on === exp_chan(), {req, " chan_on"}, {16'h0, chan_on}, {16'h0, exp_chan()});
  endtask

  task automatic t_reset();
    check(chan_on === 16'h0, "R10 outputs off", {16'h0, chan_on}, 32'h0);
    check(spi_miso === 1'b0, "R13 miso idle", {31'h0, spi_miso}, 32'h0);
    do_frame(16'h0055, "R10 first reply all ones");
  endtask

  task automatic t_full_diag();
    fault_code = 32'hE41B_6C93;
    do_frame(16'h0F00, "R5 low bank diag");
    do_frame(16'h00AA, "R5 high bank diag R6");
    do_frame(16'h0000, "R5 low bank diag second");
  endtask

  task automatic t_or_write();
    do_frame(16'h30A5, "R3 or low");
    do_frame(16'h3F0F, "R3 or high R5");
    do_frame(16'h3050, "R3 or accumulates");
  endtask

  task automatic t_and_write();
    do_frame(16'hFF3C, "R4 and high");
    do_frame(16'hF0F1, "R4 and low");
    do_frame(16'h0000, "R4 reply after and");
  endtask

  task automatic t_input_status();
    direct_in = 8'h96;
    fault_code = 32'hFF3F_F3FF;
    do_frame(16'hC0FF, "R7 input status R9");
    do_frame(16'h0000, "R7 reply content");
    check(spi_miso === 1'b0, "R13 miso idle after frame", {31'h0, spi_miso}, 32'h0);
    direct_in = 8'h00;
  endtask

  task automatic t_merge();
    direct_in = 8'hF0;
    wait_clk(2);
    check(chan_on === exp_chan(), "R9 high pins merge", {16'h0, chan_on}, {16'h0, exp_chan()});
    direct_in = 8'h0F;
    wait_clk(2);
    check(chan_on === exp_chan(), "R9 low pins merge", {16'h0, chan_on}, {16'h0, exp_chan()});
    direct_in = 8'h00;
    wait_clk(2);
  endtask

  task automatic t_echo();
    do_frame(16'hA000, "R8 arm loopback");
    do_frame(16'h30FF, "R8 loopback mirrors mosi");
    do_frame(16'h5555, "R8 reply after loopback");
    do_frame(16'hAF12, "R8 arm high bank");
    do_frame(16'h5A3C, "R8 loopback second");
  endtask

  task automatic t_bad_length();
    logic [15:0] rx;
    do_frame(16'h0000, "R11 prime diag");
    spi_xfer(16'h30FF, 12, rx);
    check(chan_on === exp_chan(), "R11 short frame no write", {16'h0, chan_on}, {16'h0, exp_chan()});
    spi_xfer(16'h3FFF, 17, rx);
    check(chan_on === exp_chan(), "R11 long frame no write", {16'h0, chan_on}, {16'h0, exp_chan()});
    do_frame(16'h0000, "R11 pending reply kept");
  endtask

  task automatic t_bad_cmd();
    do_frame(16'h35FF, "R2 bad bank");
    do_frame(16'h0000, "R2 bad bank reply ones");
    do_frame(16'h50FF, "R12 unknown opcode");
    do_frame(16'h3F80, "R12 reply ones R1");
    do_frame(16'h0000, "R1 final");
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_full_diag();
    t_or_write();
    t_and_write();
    t_input_status();
    t_merge();
    t_echo();
    t_bad_length();
    t_bad_cmd();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule